// File: doc/BRIEF.md
# Cascadable Segment Row Serializer

This block turns one pixel row of a character line into a serial bit stream and latches the part it owns onto 40 segment outputs. A row starts with a start pulse that carries the number of characters in the line. The block walks the characters from the rightmost position to the leftmost. It presents the index of the character it needs on `char_idx`, and an upstream glyph source answers on `pix_in` with that character's 5-pixel row pattern. The block shifts each pattern into a 40-bit register one bit per clock.

The register shifts from its top toward bit 0. Each bit pushed out of bit 0 appears on `ser_out`, qualified by `ser_vld`. Identical extender stages downstream can capture that stream and keep eight further characters each. After the final shift, a one-cycle strobe appears on `latch_out` and `done`. At the end of that strobe cycle, the register is copied to `seg_out`. Because the rightmost character enters first, this stage keeps the last 40 bits it sees, which are the leftmost eight characters.

The row stream runs only from its own counters, so nothing else can disturb it while a row is in progress.

Top module: `seg_row_serializer`

## Requirements
- R1: During and right after reset, `seg_out`, `busy`, `done`, `latch_out`, `ser_out` and `ser_vld` are all 0.
- R2: A start pulse with `row_chars` in 1..MAX_CHARS (default 80), taken while idle, raises `busy` on the next cycle. `char_idx` then shows `row_chars`-1 and steps down by one after every 5 shift cycles, ending at 0.
- R3: Within one character, `pix_in[0]` is shifted first and `pix_in[4]` last, so `pix_in[4]` (the leftmost pixel) lands at the highest bit of its latched field.
- R4: `done` and `latch_out` are high together for exactly one cycle. That cycle is 5×`row_chars`+1 cycles after the cycle in which start was sampled. `busy` falls as the strobe rises.
- R5: At the end of the strobe cycle, `seg_out[39-5k -: 5]` equals the pattern of character k (k = 0 is leftmost), for every k < min(8, `row_chars`).
- R6: For a row shorter than eight characters, the lower fields of `seg_out` hold the bits that were shifted in earlier: the previous register contents moved down by 5×`row_chars` places (zero after reset).
- R7: Every shift cycle is followed by one cycle with `ser_vld` high, in which `ser_out` carries the bit that left register bit 0. The stream therefore equals the sequence of shifted-in bits delayed by 40 shifts, with zeros first after reset. `ser_vld` is low in every other cycle.
- R8: A start pulse is ignored while `busy` is high, and also when `row_chars` is 0 or greater than MAX_CHARS.
- R9: `seg_out` changes only at the clock edge that ends a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a row |
| row_chars | input | 7 | Characters in the row, 1..MAX_CHARS |
| pix_in | input | 5 | Row pattern of character `char_idx`; bit 4 is the leftmost pixel |
| char_idx | output | 7 | Character whose pattern is needed |
| busy | output | 1 | Row in progress |
| ser_out | output | 1 | Serial bit leaving the register |
| ser_vld | output | 1 | `ser_out` holds a new bit |
| latch_out | output | 1 | Latch strobe for downstream stages |
| done | output | 1 | Row finished, one-cycle pulse |
| seg_out | output | 40 | Latched segment row |

## Verification
The bound checker watches, on every cycle, the single-cycle width of the strobe and its link to the fall of `busy`. It also watches that `ser_vld` follows shift activity, that `seg_out` holds outside strobe cycles, and that an idle block without a valid start stays idle. The bench scenarios show the behaviour that depends on data and ordering: right-to-left character order, pixel order inside each field, and the exact strobe cycle for short, eight-character and maximum rows. They also show stale lower fields after short rows, the 40-shift delay of the serial stream, and rejected starts.

// File: rtl/seg_row_serializer.sv
module seg_row_serializer #(
  parameter int SEG_W     = 40,
  parameter int PIX_W     = 5,
  parameter int MAX_CHARS = 80,
  localparam int CW = $clog2(MAX_CHARS + 1),
  localparam int PW = $clog2(PIX_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    row_chars,
  input  logic [PIX_W-1:0] pix_in,
  output logic [CW-1:0]    char_idx,
  output logic             busy,
  output logic             ser_out,
  output logic             ser_vld,
  output logic             latch_out,
  output logic             done,
  output logic [SEG_W-1:0] seg_out
);
  logic [SEG_W-1:0] sr;
  logic [PW-1:0]    pix_cnt;
  logic             lat;

  wire last_pix    = pix_cnt == PW'(PIX_W - 1);
  wire final_shift = busy && last_pix && char_idx == '0;
  wire accept      = start && !busy && row_chars != '0 && row_chars <= CW'(MAX_CHARS);

  assign latch_out = lat;
  assign done      = lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      seg_out  <= '0;
      pix_cnt  <= '0;
      char_idx <= '0;
      busy     <= 1'b0;
      lat      <= 1'b0;
      ser_out  <= 1'b0;
      ser_vld  <= 1'b0;
    end else begin
      lat     <= final_shift;
      ser_vld <= busy;
      if (lat) seg_out <= sr;
      if (busy) begin
        sr      <= {pix_in[pix_cnt], sr[SEG_W-1:1]};
        ser_out <= sr[0];
        pix_cnt <= last_pix ? '0 : pix_cnt + 1'b1;
        if (last_pix) begin
          if (char_idx == '0) busy <= 1'b0;
          else char_idx <= char_idx - 1'b1;
        end
      end else if (accept) begin
        busy     <= 1'b1;
        char_idx <= row_chars - 1'b1;
        pix_cnt  <= '0;
      end
    end
  end
endmodule

module seg_row_serializer_chk #(
  parameter int SEG_W     = 40,
  parameter int MAX_CHARS = 80,
  localparam int CW = $clog2(MAX_CHARS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CW-1:0]    row_chars,
  input logic [CW-1:0]    char_idx,
  input logic             busy,
  input logic             ser_vld,
  input logic             latch_out,
  input logic             done,
  input logic [SEG_W-1:0] seg_out
);
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_busy_end_r4: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (done && latch_out));
  p_seg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n) !done |=> $stable(seg_out));
  p_vld_on_r7: assert property (@(posedge clk) disable iff (!rst_n) busy |=> ser_vld);
  p_vld_off_r7: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> !ser_vld);
  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n) busy |-> char_idx < CW'(MAX_CHARS));
  p_idle_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (!start || row_chars == '0)) |=> !busy);
endmodule

bind seg_row_serializer seg_row_serializer_chk #(.SEG_W(SEG_W), .MAX_CHARS(MAX_CHARS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .row_chars(row_chars), .char_idx(char_idx),
  .busy(busy), .ser_vld(ser_vld), .latch_out(latch_out), .done(done), .seg_out(seg_out)
);

// File: tb/seg_row_serializer_test.sv
module seg_row_serializer_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic [6:0] row_chars = '0;
  logic [4:0] pix_in;
  logic [6:0] char_idx;
  logic busy, ser_out, ser_vld, latch_out, done;
  logic [39:0] seg_out;
  int checks = 0, fails = 0, ser_errs = 0, out_n = 0, cur_seed = 0;
  bit hist[$];

  always #10 clk = ~clk;

  seg_row_serializer uut (.clk(clk), .rst_n(rst_n), .start(start), .row_chars(row_chars),
    .pix_in(pix_in), .char_idx(char_idx), .busy(busy), .ser_out(ser_out), .ser_vld(ser_vld),
    .latch_out(latch_out), .done(done), .seg_out(seg_out));

  function automatic logic [4:0] pat(int s, int k);
    int v = s * 11 + k * 7 + k * k * 3 + 5;
    return v[4:0];
  endfunction

  assign pix_in = pat(cur_seed, int'(char_idx));

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [39:0] model_seg();
    logic [39:0] m = '0;
    for (int i = 0; i < 40; i++)
      if (hist.size() - 1 - i >= 0) m[39-i] = hist[hist.size()-1-i];
    return m;
  endfunction

  // R7 stream monitor: bit j out equals shifted-in bit j-40
  always @(negedge clk) if (rst_n && ser_vld) begin
    if (ser_out !== ((out_n < 40) ? 1'b0 : hist[out_n-40])) ser_errs++;
    out_n++;
  end

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({seg_out, busy, done, latch_out, ser_out, ser_vld} == '0, "R1", "reset outputs",
          64'({seg_out, busy, done, latch_out, ser_out, ser_vld}), 0);
  endtask

  task automatic t_row(int n, int seed, int poke_at);
    int cnt = 1, e0 = ser_errs;
    logic [39:0] exp;
    cur_seed = seed;
    for (int k = n - 1; k >= 0; k--)
      for (int b = 0; b < 5; b++) hist.push_back(pat(seed, k)[b]);
    start = 1; row_chars = 7'(n);
    @(negedge clk);
    start = 0;
    check(busy && char_idx == 7'(n - 1), "R2", "busy and first char_idx", 64'(char_idx), 64'(n - 1));
    while (!done && cnt < 1000) begin
      @(negedge clk);
      if (cnt == 5) check(char_idx == 7'(n - 1 - (n > 1 ? 1 : 0)), "R2", "char_idx step",
                          64'(char_idx), 64'(n - 1 - (n > 1 ? 1 : 0)));
      if (cnt == poke_at) begin start = 1; row_chars = 7'd2; end else start = 0;
      cnt++;
    end
    start = 0;
    check(cnt == 5 * n + 1 && latch_out && !busy, "R4", "strobe cycle", 64'(cnt), 64'(5 * n + 1));
    @(negedge clk);
    check(!done && !latch_out, "R4", "strobe width", 64'(done), 0);
    exp = model_seg();
    check(seg_out == exp, "R6", "latched register vs shift history", 64'(seg_out), 64'(exp));
    for (int k = 0; k < 8 && k < n; k++)
      check(seg_out[39-5*k -: 5] == pat(seed, k), "R5/R3", $sformatf("field %0d", k),
            64'(seg_out[39-5*k -: 5]), 64'(pat(seed, k)));
    repeat (2) @(negedge clk);
    check(ser_errs == e0 && !ser_vld, "R7", "serial stream", 64'(ser_errs - e0), 0);
    if (poke_at >= 0) check(!busy, "R8", "start while busy ignored", 64'(busy), 0);
  endtask

  task automatic t_ignore(int n);
    logic [39:0] s0 = seg_out;
    start = 1; row_chars = 7'(n);
    @(negedge clk);
    start = 0;
    check(!busy, "R8", $sformatf("start with %0d chars ignored", n), 64'(busy), 0);
    repeat (6) @(negedge clk);
    check(!done && !ser_vld && seg_out == s0, "R8", "no row after rejected start", 64'(seg_out), 64'(s0));
  endtask

  task automatic t_hold();
    logic [39:0] s0 = seg_out;
    repeat (10) @(negedge clk);
    check(seg_out == s0, "R9", "segments hold while idle", 64'(seg_out), 64'(s0));
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_row(8, 1, -1);
    t_row(3, 2, -1);
    t_row(20, 3, -1);
    t_hold();
    t_row(80, 4, -1);
    t_ignore(0);
    t_ignore(81);
    t_row(8, 5, 12);
    t_row(1, 6, -1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule